// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a 16-bit accumulator driven by one external input line that has already been synchronized to the bus clock. A mode bit selects what it counts. In event mode it counts transitions of the input in a selected direction. In gated mode it counts ticks of a divide-by-64 prescaler, but only while the input is at a selected level.

Every input change passes through a glitch filter before the counter sees it. The filter accepts a new level only after the line has held that level for three consecutive bus clocks. Anything as short as two clocks is dropped.

Two sticky flags report to the surrounding logic: an edge flag and an overflow flag. Writing 1 to a flag clears it. A load port lets software preset the count. Disabling the block freezes the count and clears the prescaler.

Top module: `pulse_acc`

## Requirements
- R1: After reset, `count` is 0 and both `ovf_flag` and `edge_flag` are 0.
- R2: With `gated_mode`=0 and `en`=1, each accepted input transition to the level given by `pol_sel` adds one to `count` and sets `edge_flag`. `pol_sel`=1 selects rising transitions and `pol_sel`=0 selects falling ones.
- R3: A new input level is accepted only after it has been present at three consecutive rising clock edges. Pulses of two cycles or less leave `count` unchanged, and a pulse of exactly three cycles is counted.
- R4: With `gated_mode`=1 and `en`=1, `count` rises by one every 64 clocks while the accepted input equals `pol_sel`. It does not rise while the input is at the other level.
- R5: The divide-by-64 prescaler restarts from zero whenever `en` is 0. Enabled intervals shorter than 64 clocks therefore never add a count, however many of them there are.
- R6: In gated mode, the accepted transition out of the active level sets `edge_flag`. The transition into the active level does not set it.
- R7: An increment from 0xFFFF wraps `count` to 0x0000 and sets `ovf_flag`.
- R8: `clr_flags` is write-1-to-clear: bit 0 clears `edge_flag` and bit 1 clears `ovf_flag`. A set of a flag in the same cycle wins over its clear.
- R9: While `en`=0, `count` holds its value and neither flag is set.
- R10: `wr_cnt`=1 loads `wr_data` into `count` on the next edge. A load takes priority over an increment and never sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_in | input | 1 | Accumulator input, already synchronized |
| en | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 0: event counting, 1: gated time accumulation |
| pol_sel | input | 1 | Event mode: 1 rising, 0 falling. Gated mode: active level |
| wr_cnt | input | 1 | Load strobe for the count |
| wr_data | input | 16 | Value to load into the count |
| clr_flags | input | 2 | Write-1-to-clear: bit 0 edge flag, bit 1 overflow flag |
| count | output | 16 | Accumulator value |
| ovf_flag | output | 1 | Sticky wrap flag |
| edge_flag | output | 1 | Sticky input-edge flag |

## Verification
The assertions assume that `wr_cnt` and the mode and enable inputs are plain synchronous levels, and that the only way `count` can change is a load or a single increment. The stimulus keeps every pulse and every gap on `acc_in` at least three cycles long unless a check is aimed at the filter itself. It changes `pol_sel` and `gated_mode` only while the filtered input is steady, so a mode switch never creates a spurious transition. All inputs change on the falling clock edge, and gated intervals are timed in whole clock counts from the moment `en` rises, so the prescaler phase is known at every check.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 6,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_in,
  input  logic             en,
  input  logic             gated_mode,
  input  logic             pol_sel,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       clr_flags,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             edge_flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [FILT_LEN-1:0] samp;
  logic                filt;
  logic [PRE_W-1:0]    presc;

  wire lvl_change = filt ? ~|samp : &samp;
  wire new_lvl    = ~filt;
  wire tick       = &presc;
  wire at_active  = (filt == pol_sel);

  wire ev_edge  = en & ~gated_mode & lvl_change & (new_lvl == pol_sel);
  wire gate_end = en &  gated_mode & lvl_change & at_active;
  wire gate_inc = en &  gated_mode & at_active & tick;
  wire inc      = ev_edge | gate_inc;
  wire wrap     = inc & ~wr_cnt & (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= '0;
      filt <= 1'b0;
    end else begin
      samp <= {samp[FILT_LEN-2:0], acc_in};
      if (lvl_change) filt <= new_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   presc <= '0;
    else if (!en) presc <= '0;
    else          presc <= presc + PRE_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (wr_cnt) count <= wr_data;
    else if (inc)    count <= count + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (ev_edge | gate_end) edge_flag <= 1'b1;
      else if (clr_flags[0])  edge_flag <= 1'b0;
      if (wrap)               ovf_flag  <= 1'b1;
      else if (clr_flags[1])  ovf_flag  <= 1'b0;
    end
  end

endmodule

// File: rtl/pulse_acc_chk.sv
module pulse_acc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             gated_mode,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             edge_flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt) |=> $stable(count));

  a_r9_no_flag_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!$rose(edge_flag) && !$rose(ovf_flag)));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count == $past(wr_data)));

  a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && count == CNT_MAX) |=> (count == CNT_MAX || ovf_flag));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (count == $past(count) || count == $past(count) + CNT_ONE));

  a_r2_step_sets_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(gated_mode) && !$past(wr_cnt) &&
     count == $past(count) + CNT_ONE) |-> edge_flag);

endmodule

bind pulse_acc pulse_acc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gated_mode(gated_mode),
  .wr_cnt(wr_cnt), .wr_data(wr_data), .count(count),
  .ovf_flag(ovf_flag), .edge_flag(edge_flag)
);

// File: tb/pulse_acc_test.sv
module pulse_acc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_in = 1'b0, en = 1'b0, gated_mode = 1'b0, pol_sel = 1'b1;
  logic        wr_cnt = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  clr_flags = '0;
  logic [15:0] count;
  logic        ovf_flag, edge_flag;

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;

  string       tag_q[$];
  logic [17:0] exp_q[$];

  always #5 clk = ~clk;

  pulse_acc uut (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .en(en),
    .gated_mode(gated_mode), .pol_sel(pol_sel), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .clr_flags(clr_flags), .count(count),
    .ovf_flag(ovf_flag), .edge_flag(edge_flag)
  );

  // Monitor: pops expected items and compares on the falling edge.
  always @(negedge clk) begin
    if (tag_q.size() > 0) begin
      string       t;
      logic [17:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      n_tests++;
      if ({count, ovf_flag, edge_flag} !== e) begin
        n_fail++;
        $display("FAIL %s: count=%h ovf=%b edge=%b expected count=%h ovf=%b edge=%b",
                 t, count, ovf_flag, edge_flag, e[17:2], e[1], e[0]);
      end
    end
  end

  task automatic expect_state(string tag, logic [15:0] c, logic o, logic e);
    tag_q.push_back(tag);
    exp_q.push_back({c, o, e});
    wait (tag_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int w, int gap);
    acc_in = 1'b1;
    cyc(w);
    acc_in = 1'b0;
    cyc(gap);
  endtask

  task automatic clear(logic [1:0] m);
    clr_flags = m;
    cyc(1);
    clr_flags = '0;
    cyc(1);
  endtask

  task automatic load(logic [15:0] v);
    wr_data = v;
    wr_cnt  = 1'b1;
    cyc(1);
    wr_cnt  = 1'b0;
    cyc(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_state("R1 reset", 16'h0000, 0, 0);

    en = 1'b1; gated_mode = 1'b0; pol_sel = 1'b1;
    for (int i = 0; i < 5; i++) pulse(4, 4);
    cyc(4);
    expect_state("R2 rising events", 16'd5, 0, 1);

    for (int i = 0; i < 4; i++) pulse(2, 4);
    cyc(4);
    expect_state("R3 two-cycle pulses ignored", 16'd5, 0, 1);
    pulse(3, 4);
    cyc(4);
    expect_state("R3 three-cycle pulse counted", 16'd6, 0, 1);

    clear(2'b01);
    expect_state("R8 edge flag cleared", 16'd6, 0, 0);

    pol_sel = 1'b0;
    for (int i = 0; i < 3; i++) pulse(4, 4);
    cyc(4);
    expect_state("R2 falling events", 16'd9, 0, 1);

    load(16'hFFFE);
    expect_state("R10 load", 16'hFFFE, 0, 1);

    for (int i = 0; i < 2; i++) pulse(4, 4);
    cyc(4);
    expect_state("R7 wrap sets overflow", 16'h0000, 1, 1);

    clear(2'b11);
    expect_state("R8 both flags cleared", 16'h0000, 0, 0);

    en = 1'b0;
    for (int i = 0; i < 3; i++) pulse(4, 4);
    cyc(4);
    expect_state("R9 disabled holds", 16'h0000, 0, 0);

    gated_mode = 1'b1; pol_sel = 1'b1; acc_in = 1'b1;
    cyc(6);
    en = 1'b1;
    cyc(330);
    en = 1'b0;
    cyc(2);
    expect_state("R4 gated five ticks", 16'd5, 0, 0);

    for (int i = 0; i < 3; i++) begin
      en = 1'b1;
      cyc(63);
      en = 1'b0;
      cyc(2);
    end
    expect_state("R5 prescaler restarts", 16'd5, 0, 0);

    acc_in = 1'b0;
    cyc(6);
    en = 1'b1;
    cyc(200);
    expect_state("R4 inactive gate no count", 16'd5, 0, 0);

    acc_in = 1'b1;
    cyc(10);
    expect_state("R6 leading gate edge no flag", count, 0, 0);
    acc_in = 1'b0;
    cyc(6);
    expect_state("R6 trailing gate edge sets flag", count, 0, 1);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule